// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent page mappings so that a virtual address can be turned into a physical address without a trip to the page table. A request carries a 32-bit virtual address and an access kind (read, write or execute). The upper 20 bits, the page number, are compared against every stored entry in the same cycle. One cycle later the block answers with exactly one of three outcomes: a hit with the physical address, a protection fault, or a miss.

On a miss, an external walker or software loader fetches the mapping and installs it through the fill port. Each fill replaces one entry. When the replaced entry was in use, the block reports its page number and modified bit on a one-cycle writeback strobe, so the agent can update the page table. A flush input empties the whole cache in one cycle for a context switch. The agent must copy out dirty state before flushing, and must never install a page number that is already present.

Top module: `tlb_xlate`

## Requirements
- R1: A request whose page number matches a valid entry that permits the access gives, one cycle later, rsp_hit=1 and rsp_paddr = {entry frame number, request address bits [11:0]}.
- R2: The protection code has read at bit 2, write at bit 1 and execute at bit 0. The access code is 0 for read, 1 for write, 2 for execute, and 3 is treated as read. A valid match whose code lacks the needed bit gives rsp_fault=1, rsp_hit=0 and rsp_paddr=0 one cycle later.
- R3: A request with no valid matching entry gives rsp_miss=1 and rsp_paddr=0 one cycle later.
- R4: rsp_valid equals req_valid of the previous cycle. While rsp_valid=1, exactly one of rsp_hit, rsp_miss and rsp_fault is 1. While rsp_valid=0, all three are 0.
- R5: A write that hits a writable entry sets that entry's modified bit. The bit is later reported as wb_dirty=1 when the entry is evicted.
- R6: A fill writes the page number, frame number, protection code and modified bit of the new entry from the fill inputs, including fill_dirty.
- R7: The fill victim is the lowest-index invalid entry if any exists. Otherwise it is the entry named by a round-robin pointer. The pointer starts at 0 after reset and steps by one, modulo the entry count, on every accepted fill.
- R8: A fill that replaces a valid entry raises wb_valid for exactly one cycle, in the cycle after the fill, with wb_vpn and wb_dirty of the replaced entry. A fill into an invalid entry raises no strobe.
- R9: flush clears every valid bit at the next edge and leaves the round-robin pointer unchanged. A fill in the same cycle as flush is dropped and produces no writeback.
- R10: After reset every entry is invalid and all outputs are 0.
- R11: A lookup made in the same cycle as a fill or a flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| fill_valid | input | 1 | Install a new entry |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_pfn | input | 20 | Frame number of the new entry |
| fill_perm | input | 3 | Protection code {R,W,X} of the new entry |
| fill_dirty | input | 1 | Initial modified bit of the new entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No valid mapping found |
| rsp_fault | output | 1 | Mapping found but access not permitted |
| rsp_paddr | output | 32 | Physical address on a hit, else 0 |
| wb_valid | output | 1 | A valid entry was evicted |
| wb_vpn | output | 20 | Page number of the evicted entry |
| wb_dirty | output | 1 | Modified bit of the evicted entry |

## Verification
A wrong valid, tag or protection field in an entry shows at the ports on the very next lookup of that page, one cycle after the request, as a wrong outcome or a wrong frame. A lost or spurious modified bit stays hidden until that entry is evicted, so the bench forces evictions after dirtying writes and compares wb_dirty. A round-robin pointer that is off by one appears as a wrong wb_vpn on the first eviction from a full cache. A reference model of the entries follows every fill, write hit and flush, so such a fault is caught within a few dozen cycles of random traffic.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 2;
  localparam int PERM_W = 1;
  localparam int PERM_X = 0;

  function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] acc);
    logic ok;
    case (acc)
      ACC_WRITE: ok = perm[PERM_W];
      ACC_EXEC:  ok = perm[PERM_X];
      default:   ok = perm[PERM_R];
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  logic [2:0] perm,
  input  logic [1:0] acc,
  output logic       allow,
  output logic       is_write
);

  always_comb begin
    allow    = perm_allows(perm, acc);
    is_write = (acc == ACC_WRITE);
  end

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic             adv,
  output logic [IDX_W-1:0] victim_idx
);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  // lowest-index invalid entry
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (adv) begin
      rr_d = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
    victim_idx = free_any ? free_idx : rr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else begin
      rr_q <= rr_d;
    end
  end

  // R7: a free slot is always preferred over a live one
  p_victim_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&valid_vec)) |-> !valid_vec[victim_idx]);

  // R7: pointer stays inside the table
  p_rr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rr_q) < N);

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  // lookup
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit_any,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PFN_W-1:0] hit_pfn,
  output logic [2:0]       hit_perm,
  // modified-bit update
  input  logic             mark_we,
  input  logic [IDX_W-1:0] mark_idx,
  // fill
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [2:0]       fill_perm,
  input  logic             fill_dirty,
  // victim readout
  output logic [N-1:0]     valid_vec,
  output logic             vic_valid,
  output logic [VPN_W-1:0] vic_vpn,
  output logic             vic_dirty
);

  logic [N-1:0]     valid_q, valid_d;
  logic [N-1:0]     dirty_q, dirty_d;
  logic [N-1:0]     load;
  logic [N-1:0]     match;
  logic [VPN_W-1:0] vpn_q  [N];
  logic [PFN_W-1:0] pfn_q  [N];
  logic [2:0]       perm_q [N];

  // one comparator per entry, all in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    hit_pfn  = pfn_q[hit_idx];
    hit_perm = perm_q[hit_idx];
  end

  // next state: fill beats modified-bit update, flush beats everything for valid
  always_comb begin
    for (int i = 0; i < N; i++) begin
      load[i]    = fill_we && (fill_idx == IDX_W'(i));
      valid_d[i] = valid_q[i];
      dirty_d[i] = dirty_q[i];
      if (mark_we && (mark_idx == IDX_W'(i))) dirty_d[i] = 1'b1;
      if (load[i]) begin
        valid_d[i] = 1'b1;
        dirty_d[i] = fill_dirty;
      end
      if (flush) valid_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  // payload without reset, enabled per entry
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (load[i]) begin
        vpn_q[i]  <= fill_vpn;
        pfn_q[i]  <= fill_pfn;
        perm_q[i] <= fill_perm;
      end
    end
  end

  always_comb begin
    valid_vec = valid_q;
    vic_valid = valid_q[fill_idx];
    vic_vpn   = vpn_q[fill_idx];
    vic_dirty = dirty_q[fill_idx];
  end

  // R9: a flush leaves no live entry behind
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  // R6: a filled slot is live afterwards unless flushed
  p_fill_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !flush) |=> valid_vec[$past(fill_idx)]);

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int OFFS_W      = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [1:0]               req_acc,
  input  logic                     fill_valid,
  input  logic [VA_W-OFFS_W-1:0]   fill_vpn,
  input  logic [PA_W-OFFS_W-1:0]   fill_pfn,
  input  logic [2:0]               fill_perm,
  input  logic                     fill_dirty,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic                     rsp_fault,
  output logic [PA_W-1:0]          rsp_paddr,
  output logic                     wb_valid,
  output logic [VA_W-OFFS_W-1:0]   wb_vpn,
  output logic                     wb_dirty
);

  localparam int VPN_W = VA_W - OFFS_W;
  localparam int PFN_W = PA_W - OFFS_W;
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [VPN_W-1:0]   lk_vpn;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic [2:0]         hit_perm;
  logic               allow;
  logic               is_write;
  logic               mark_we;
  logic               fill_fire;
  logic [IDX_W-1:0]   victim_idx;
  logic [NUM_ENTRIES-1:0] valid_vec;
  logic               vic_valid;
  logic [VPN_W-1:0]   vic_vpn;
  logic               vic_dirty;

  assign lk_vpn = req_vaddr[VA_W-1:OFFS_W];

  tlb_entry_array #(
    .N(NUM_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .lk_vpn     (lk_vpn),
    .hit_any    (hit_any),
    .hit_idx    (hit_idx),
    .hit_pfn    (hit_pfn),
    .hit_perm   (hit_perm),
    .mark_we    (mark_we),
    .mark_idx   (hit_idx),
    .fill_we    (fill_fire),
    .fill_idx   (victim_idx),
    .fill_vpn   (fill_vpn),
    .fill_pfn   (fill_pfn),
    .fill_perm  (fill_perm),
    .fill_dirty (fill_dirty),
    .valid_vec  (valid_vec),
    .vic_valid  (vic_valid),
    .vic_vpn    (vic_vpn),
    .vic_dirty  (vic_dirty)
  );

  tlb_perm_chk u_perm (
    .perm     (hit_perm),
    .acc      (req_acc),
    .allow    (allow),
    .is_write (is_write)
  );

  tlb_victim_sel #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_vic (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .adv        (fill_fire),
    .victim_idx (victim_idx)
  );

  assign fill_fire = fill_valid && !flush;
  assign mark_we   = req_valid && hit_any && allow && is_write;

  // response next state
  logic            rsp_valid_d, rsp_hit_d, rsp_miss_d, rsp_fault_d;
  logic [PA_W-1:0] rsp_paddr_d;
  logic            wb_valid_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_hit_d   = req_valid && hit_any && allow;
    rsp_fault_d = req_valid && hit_any && !allow;
    rsp_miss_d  = req_valid && !hit_any;
    rsp_paddr_d = rsp_hit_d ? {hit_pfn, req_vaddr[OFFS_W-1:0]} : '0;
    wb_valid_d  = fill_fire && vic_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      wb_valid  <= 1'b0;
      wb_vpn    <= '0;
      wb_dirty  <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_miss  <= rsp_miss_d;
      rsp_fault <= rsp_fault_d;
      rsp_paddr <= rsp_paddr_d;
      wb_valid  <= wb_valid_d;
      if (wb_valid_d) begin
        wb_vpn   <= vic_vpn;
        wb_dirty <= vic_dirty;
      end
    end
  end

  // R4: response follows request by one cycle
  p_rsp_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R4: one outcome per response
  p_rsp_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  // R4: quiet when idle
  p_rsp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  // R1: offset passes through untranslated
  p_offs_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_paddr[OFFS_W-1:0] == $past(req_vaddr[OFFS_W-1:0])));

  // R2: no address on a fault
  p_fault_noaddr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0));

  // R8: writeback only after an accepted fill
  p_wb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($past(fill_valid) && !$past(flush)));

  // R9: a flush cycle never evicts
  p_flush_nowb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !wb_valid);

endmodule

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush, req_valid, fill_valid, fill_dirty;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic [19:0] fill_vpn, fill_pfn;
  logic [2:0]  fill_perm;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        wb_valid, wb_dirty;
  logic [19:0] wb_vpn;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model
  bit          m_val [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  logic [2:0]  m_perm[N];
  bit          m_dty [N];
  int          m_rr;

  always #10 clk = ~clk;

  tlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .fill_dirty(fill_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_dirty(wb_dirty)
  );

  function automatic bit allow_f(input logic [2:0] p, input logic [1:0] a);
    if (a == 2'd1) return p[1];
    if (a == 2'd2) return p[0];
    return p[2];
  endfunction

  function automatic int find_f(input logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit rv, input logic [31:0] va, input logic [1:0] ac,
                      input bit fv, input logic [19:0] fvpn, input logic [19:0] fpfn,
                      input logic [2:0] fperm, input bit fd, input bit fl,
                      input string tag);
    int    idx, vic;
    bit    e_hit, e_miss, e_fault, e_wb, e_wbd;
    logic [31:0] e_pa;
    logic [19:0] e_wbv;
    string t;
    req_valid = rv; req_vaddr = va; req_acc = ac;
    fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn;
    fill_perm = fperm; fill_dirty = fd; flush = fl;
    // lookup on pre-edge contents
    idx = find_f(va[31:12]);
    e_hit = 0; e_miss = 0; e_fault = 0; e_pa = '0;
    if (rv) begin
      if (idx < 0) e_miss = 1;
      else if (allow_f(m_perm[idx], ac)) begin
        e_hit = 1; e_pa = {m_pfn[idx], va[11:0]};
      end else e_fault = 1;
    end
    // victim capture
    e_wb = 0; e_wbd = 0; e_wbv = '0; vic = -1;
    if (fv && !fl) begin
      for (int i = N - 1; i >= 0; i--) if (!m_val[i]) vic = i;
      if (vic < 0) vic = m_rr;
      e_wb = m_val[vic]; e_wbv = m_vpn[vic]; e_wbd = m_dty[vic];
    end
    // state update
    if (e_hit && ac == 2'd1) m_dty[idx] = 1;
    if (vic >= 0) begin
      m_val[vic] = 1; m_vpn[vic] = fvpn; m_pfn[vic] = fpfn;
      m_perm[vic] = fperm; m_dty[vic] = fd;
      m_rr = (m_rr + 1) % N;
    end
    if (fl) for (int i = 0; i < N; i++) m_val[i] = 0;
    @(posedge clk);
    @(negedge clk);
    t = tag;
    if (t == "") t = !rv ? "R4" : e_hit ? "R1" : e_fault ? "R2" : "R3";
    chk("R4", "rsp_valid", 64'(rsp_valid), 64'(rv));
    chk(t, "rsp_hit",   64'(rsp_hit),   64'(e_hit));
    chk(t, "rsp_miss",  64'(rsp_miss),  64'(e_miss));
    chk(t, "rsp_fault", 64'(rsp_fault), 64'(e_fault));
    chk(t, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
    chk((tag == "") ? "R8" : tag, "wb_valid", 64'(wb_valid), 64'(e_wb));
    if (e_wb) begin
      chk((tag == "") ? "R8" : tag, "wb_vpn",   64'(wb_vpn),   64'(e_wbv));
      chk((tag == "") ? "R5" : tag, "wb_dirty", 64'(wb_dirty), 64'(e_wbd));
    end
  endtask

  task automatic look(input logic [19:0] v, input logic [11:0] o,
                      input logic [1:0] a, input string tag);
    step(1, {v, o}, a, 0, '0, '0, '0, 0, 0, tag);
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p,
                      input logic [2:0] pm, input bit d, input string tag);
    step(0, '0, 2'd0, 1, v, p, pm, d, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] pm;
    void'($urandom(32'd20240611));
    rst_n = 0; flush = 0; req_valid = 0; req_vaddr = '0; req_acc = '0;
    fill_valid = 0; fill_vpn = '0; fill_pfn = '0; fill_perm = '0; fill_dirty = 0;
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_dty[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
    end
    m_rr = 0;
    repeat (3) @(negedge clk);
    // R10: outputs idle in reset
    chk("R10", "rsp_valid", 64'(rsp_valid), 0);
    chk("R10", "rsp_hit|miss|fault", 64'({rsp_hit, rsp_miss, rsp_fault}), 0);
    chk("R10", "rsp_paddr", 64'(rsp_paddr), 0);
    chk("R10", "wb_valid", 64'(wb_valid), 0);
    rst_n = 1;
    @(negedge clk);
    look(20'h00100, 12'h000, 2'd0, "R10");
    // R7: fill free slots in index order, no writeback
    for (int i = 0; i < N; i++) begin
      case (i)
        0: pm = 3'b110;
        1: pm = 3'b100;
        2: pm = 3'b101;
        3: pm = 3'b001;
        default: pm = 3'b111;
      endcase
      fill(20'h00100 + 20'(i), 20'hA0000 + 20'(i), pm, (i == 7), "R7");
    end
    look(20'h00101, 12'hABC, 2'd0, "R1");
    look(20'h00106, 12'h123, 2'd2, "R1");
    look(20'h00101, 12'h010, 2'd1, "R2");
    look(20'h00103, 12'h444, 2'd2, "R2");
    look(20'h00103, 12'h444, 2'd0, "R2");
    look(20'h00101, 12'h020, 2'd3, "R2");
    look(20'h00555, 12'h000, 2'd0, "R3");
    look(20'h00100, 12'h7FF, 2'd1, "R5");
    // pointer wrapped to 0: evict entry 0 (dirtied by write)
    fill(20'h00200, 20'hB0000, 3'b111, 0, "R5");
    fill(20'h00201, 20'hB0001, 3'b111, 0, "R8");
    // walk pointer to entry 7, filled with modified bit set
    for (int i = 2; i < N; i++)
      fill(20'h00200 + 20'(i), 20'hB0000 + 20'(i), 3'b111, 0, "R6");
    // R11: lookup of the page being evicted in the same cycle
    step(1, {20'h00200, 12'h055}, 2'd0, 1, 20'h00300, 20'hC0000, 3'b100, 1, 0, "R11");
    look(20'h00200, 12'h055, 2'd0, "R11");
    look(20'h00300, 12'h066, 2'd0, "R11");
    step(0, '0, 2'd0, 0, '0, '0, '0, 0, 0, "R4");
    // R9: flush with concurrent fill and lookup
    step(1, {20'h00300, 12'h001}, 2'd0, 1, 20'h00400, 20'hD0000, 3'b111, 0, 1, "R9");
    look(20'h00300, 12'h001, 2'd0, "R9");
    look(20'h00400, 12'h001, 2'd0, "R9");
    for (int i = 0; i < N + 2; i++)
      fill(20'h00500 + 20'(i), 20'hE0000 + 20'(i), 3'b110, 0, "R9");
    // random phase
    for (int k = 0; k < 600; k++) begin
      logic [19:0] v, fvv;
      bit rv, fv, fl;
      rv  = ($urandom % 4) != 0;
      v   = 20'h00600 + 20'($urandom % 12);
      fvv = 20'h00600 + 20'($urandom % 12);
      fv  = ($urandom % 3) == 0;
      if (find_f(fvv) >= 0) fv = 0;
      fl  = ($urandom % 50) == 0;
      step(rv, {v, 12'($urandom)}, 2'($urandom), fv, fvv, 20'($urandom),
           3'($urandom), 1'($urandom), fl, "");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule